// File: doc/BRIEF.md
# Shared Data RAM with Mirrored Instruction Store

A coprocessor's shared memory. One word-addressed array of data words is reachable from two data ports: an external system-bus port and an internal engine-bus port. Each port uses a simple request/grant handshake. The array is single-ported, so the two data ports share one access per cycle through an arbiter.

A small instruction store keeps an exact copy of the lowest region of the array. Any granted write that lands in that region updates the copy in the same cycle. A local CPU reads instructions through a third, read-only fetch port that only touches the copy. Instruction fetches therefore never take an access slot from either data port, and data traffic never stalls a fetch.

The default array size is kept modest so the default build stays small. `AW` sets the array size and can be raised to 16 for a 64K-word array.

Top module: `mirrored_dpram`

## Requirements
- R1: During and right after reset, `sys_rvalid`, `eng_rvalid` and `if_data` are 0, and neither grant is asserted while no request is present.
- R2: A granted access on either data port completes in its grant cycle. For a read, that port's `*_rvalid` is 1 in the next cycle and `*_rdata` holds the word stored at the address. A write raises no `*_rvalid`.
- R3: When both data ports request and the engine port was granted or idle in the previous cycle, the system port is granted and the engine port is not.
- R4: When the engine port requested and was not granted in the previous cycle, and both ports request now, the engine port is granted. Under continuous requests from both ports, grants therefore alternate system, engine, system, and so on.
- R5: A granted write to an address below 2^MW updates the instruction copy in the same cycle. A fetch of that address issued in a later cycle returns the written word.
- R6: A write to an address at or above 2^MW leaves every word of the instruction copy unchanged.
- R7: A fetch with `if_en` high returns the word in the next cycle. While `if_en` is low, `if_data` holds its value.
- R8: A fetch issued in the same cycle as a write to the same low address returns the old word. The new word is returned from the following cycle on.
- R9: The fetch port uses only `if_addr[MW-1:0]`. Bits at and above MW have no effect on the returned word.
- R10: Fetches have no effect on data-port grants or read data, including while both data ports contend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_req | input | 1 | System port request |
| sys_we | input | 1 | System port write enable |
| sys_addr | input | AW | System port word address |
| sys_wdata | input | DW | System port write data |
| sys_gnt | output | 1 | System port granted this cycle |
| sys_rvalid | output | 1 | System read data valid |
| sys_rdata | output | DW | System read data |
| eng_req | input | 1 | Engine port request |
| eng_we | input | 1 | Engine port write enable |
| eng_addr | input | AW | Engine port word address |
| eng_wdata | input | DW | Engine port write data |
| eng_gnt | output | 1 | Engine port granted this cycle |
| eng_rvalid | output | 1 | Engine read data valid |
| eng_rdata | output | DW | Engine read data |
| if_en | input | 1 | Instruction fetch enable |
| if_addr | input | AW | Fetch address (low MW bits used) |
| if_data | output | DW | Fetched instruction word |

## Verification
The bench builds the block with AW=6 and MW=4: a 64-word array with a 16-word instruction copy. At this size every array address is written and read back from both ports. Every copy address is fetched with several settings of the ignored upper address bits. Every write above the copy boundary is checked against the whole copy. The small sizes also make it cheap to run a long contention stretch with fetches sweeping alongside it, and to line up a write and a fetch of the same word in one cycle.

// File: rtl/mirrored_dpram.sv
module mirrored_dpram #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sys_req,
  input  logic          sys_we,
  input  logic [AW-1:0] sys_addr,
  input  logic [DW-1:0] sys_wdata,
  output logic          sys_gnt,
  output logic          sys_rvalid,
  output logic [DW-1:0] sys_rdata,
  input  logic          eng_req,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [DW-1:0] eng_wdata,
  output logic          eng_gnt,
  output logic          eng_rvalid,
  output logic [DW-1:0] eng_rdata,
  input  logic          if_en,
  input  logic [AW-1:0] if_addr,
  output logic [DW-1:0] if_data
);
  localparam int DEPTH  = 1 << AW;
  localparam int MDEPTH = 1 << MW;

  logic [DW-1:0] mem  [DEPTH];
  logic [DW-1:0] imem [MDEPTH];
  logic [DW-1:0] rd_q;
  logic          eng_lost;

  assign sys_gnt = sys_req & ~(eng_req & eng_lost);
  assign eng_gnt = eng_req & ~sys_gnt;

  wire          acc_en    = sys_gnt | eng_gnt;
  wire          acc_we    = acc_en & (sys_gnt ? sys_we : eng_we);
  wire [AW-1:0] acc_addr  = sys_gnt ? sys_addr : eng_addr;
  wire [DW-1:0] acc_wdata = sys_gnt ? sys_wdata : eng_wdata;
  wire          low_hit   = (acc_addr >> MW) == '0;
  wire          mirror_wr = acc_we & low_hit;
  wire [MW-1:0] if_idx    = if_addr[MW-1:0];

  always_ff @(posedge clk) begin
    if (acc_we) mem[acc_addr] <= acc_wdata;
    rd_q <= mem[acc_addr];
  end

  always_ff @(posedge clk) begin
    if (mirror_wr) imem[acc_addr[MW-1:0]] <= acc_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_lost   <= 1'b0;
      sys_rvalid <= 1'b0;
      eng_rvalid <= 1'b0;
      if_data    <= '0;
    end else begin
      eng_lost   <= eng_req & ~eng_gnt;
      sys_rvalid <= sys_gnt & ~sys_we;
      eng_rvalid <= eng_gnt & ~eng_we;
      if (if_en) if_data <= imem[if_idx];
    end
  end

  assign sys_rdata = rd_q;
  assign eng_rdata = rd_q;

  // R2
  sys_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_gnt && !sys_we) |=> sys_rvalid);
  // R2
  eng_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_gnt && !eng_we) |=> eng_rvalid);
  // R4
  starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_gnt) |=> (!eng_req || !sys_req || eng_gnt));
  // R5
  mirror_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mirror_wr |=> imem[$past(acc_addr[MW-1:0])] == $past(acc_wdata));
  // R7
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !if_en |=> $stable(if_data));
endmodule

// File: tb/mirrored_dpram_test.sv
`timescale 1ns/1ps
module mirrored_dpram_test;
  localparam int AW = 6, DW = 16, MW = 4;
  logic clk = 0, rst_n = 0;
  logic sys_req = 0, sys_we = 0, eng_req = 0, eng_we = 0, if_en = 0;
  logic [AW-1:0] sys_addr = 0, eng_addr = 0, if_addr = 0;
  logic [DW-1:0] sys_wdata = 0, eng_wdata = 0;
  logic sys_gnt, eng_gnt, sys_rvalid, eng_rvalid;
  logic [DW-1:0] sys_rdata, eng_rdata, if_data;
  logic [DW-1:0] model [64];
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mirrored_dpram #(.AW(AW), .DW(DW), .MW(MW)) uut (
    .clk(clk), .rst_n(rst_n),
    .sys_req(sys_req), .sys_we(sys_we), .sys_addr(sys_addr), .sys_wdata(sys_wdata),
    .sys_gnt(sys_gnt), .sys_rvalid(sys_rvalid), .sys_rdata(sys_rdata),
    .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
    .eng_gnt(eng_gnt), .eng_rvalid(eng_rvalid), .eng_rdata(eng_rdata),
    .if_en(if_en), .if_addr(if_addr), .if_data(if_data));

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sys_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    sys_req = 1; sys_we = we; sys_addr = a; sys_wdata = d;
    #1;
    while (!sys_gnt) begin @(negedge clk); #1; end
    @(negedge clk);
    sys_req = 0;
    if (we) check(!sys_rvalid, "R2 sys write rvalid", DW'(sys_rvalid), 0);
    else begin
      check(sys_rvalid, "R2 sys rvalid", DW'(sys_rvalid), 1);
      check(sys_rdata == model[a], "R2 sys rdata", sys_rdata, model[a]);
    end
    if (we) model[a] = d;
  endtask

  task automatic eng_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    eng_req = 1; eng_we = we; eng_addr = a; eng_wdata = d;
    #1;
    while (!eng_gnt) begin @(negedge clk); #1; end
    @(negedge clk);
    eng_req = 0;
    if (we) check(!eng_rvalid, "R2 eng write rvalid", DW'(eng_rvalid), 0);
    else begin
      check(eng_rvalid, "R2 eng rvalid", DW'(eng_rvalid), 1);
      check(eng_rdata == model[a], "R2 eng rdata", eng_rdata, model[a]);
    end
    if (we) model[a] = d;
  endtask

  task automatic fetch(input logic [AW-1:0] a, output logic [DW-1:0] q);
    if_en = 1; if_addr = a;
    @(negedge clk);
    q = if_data; if_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] q;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!sys_rvalid && !eng_rvalid, "R1 rvalid", DW'({sys_rvalid, eng_rvalid}), 0);
    check(if_data == 0, "R1 if_data", if_data, 0);
    check(!sys_gnt && !eng_gnt, "R1 grant", DW'({sys_gnt, eng_gnt}), 0);
    rst_n = 1;
    @(negedge clk);
    check(!sys_rvalid && !eng_rvalid && if_data == 0, "R1 after reset", if_data, 0);

    // R2 fill via system port, read via engine port
    for (int a = 0; a < 64; a++) sys_op(1, AW'(a), DW'(a * 16'h0101) ^ 16'h5A3C);
    for (int a = 0; a < 64; a++) eng_op(0, AW'(a), 0);
    for (int a = 1; a < 64; a += 2) eng_op(1, AW'(a), DW'(16'hC000 + a * 7));
    for (int a = 0; a < 64; a++) sys_op(0, AW'(a), 0);

    // R5 R9 mirror contents with ignored upper bits
    for (int a = 0; a < 16; a++) begin
      fetch(AW'(a), q);
      check(q == model[a], "R5 mirror fetch", q, model[a]);
      fetch(AW'(a | ((a % 3 + 1) << 4)), q);
      check(q == model[a], "R9 upper bits ignored", q, model[a]);
    end

    // R6 writes above the mirrored region leave the copy alone
    for (int k = 0; k < 16; k++) sys_op(1, AW'(16 + k), DW'(16'h9000 + k));
    for (int k = 0; k < 16; k++) eng_op(1, AW'(48 + k), DW'(16'h7700 + k));
    for (int k = 0; k < 16; k++) begin
      fetch(AW'(k), q);
      check(q == model[k], "R6 copy unchanged", q, model[k]);
    end

    // R7 hold while fetch disabled
    fetch(AW'(2), q);
    if_addr = AW'(9);
    @(negedge clk);
    check(if_data == model[2], "R7 hold 1", if_data, model[2]);
    if_addr = AW'(11);
    @(negedge clk);
    check(if_data == model[2], "R7 hold 2", if_data, model[2]);

    // R8 same-cycle write and fetch of one word
    eng_req = 1; eng_we = 1; eng_addr = AW'(5); eng_wdata = 16'hBEEF;
    if_en = 1; if_addr = AW'(5);
    #1;
    check(eng_gnt, "R8 eng granted", DW'(eng_gnt), 1);
    @(negedge clk);
    check(if_data == model[5], "R8 old word", if_data, model[5]);
    eng_req = 0;
    model[5] = 16'hBEEF;
    @(negedge clk);
    check(if_data == 16'hBEEF, "R8 new word next cycle", if_data, 16'hBEEF);
    if_en = 0;

    // R5 low write from system port, then fetch
    sys_op(1, AW'(12), 16'h1234);
    fetch(AW'(12), q);
    check(q == 16'h1234, "R5 write-through", q, 16'h1234);

    // R3 R4 R10 contention with concurrent fetches
    sys_req = 1; sys_we = 0; sys_addr = AW'(10);
    eng_req = 1; eng_we = 0; eng_addr = AW'(40);
    if_en = 1; if_addr = AW'(0);
    for (int c = 0; c < 10; c++) begin
      #1;
      if (c % 2 == 0) check(sys_gnt && !eng_gnt, "R3 system priority", DW'({sys_gnt, eng_gnt}), 2);
      else check(eng_gnt && !sys_gnt, "R4 engine after loss", DW'({sys_gnt, eng_gnt}), 1);
      @(negedge clk);
      if (c % 2 == 0) begin
        check(sys_rvalid && !eng_rvalid, "R10 sys read under contention", sys_rdata, model[10]);
        check(sys_rdata == model[10], "R10 sys rdata", sys_rdata, model[10]);
      end else begin
        check(eng_rvalid && !sys_rvalid, "R10 eng read under contention", eng_rdata, model[40]);
        check(eng_rdata == model[40], "R10 eng rdata", eng_rdata, model[40]);
      end
      check(if_data == model[c % 16], "R10 fetch alongside", if_data, model[c % 16]);
      if_addr = AW'((c + 1) % 16);
    end
    sys_req = 0; eng_req = 0; if_en = 0;
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule